// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called the A side and the B side. Each bus appears at the block edge as three separate signals: an input value, an output value and an output enable. Because of this, no tri-state net exists inside the design. A single active-low enable and a direction input decide which bus the block drives. At most one bus is driven at a time. When the enable is high, neither bus is driven.

Each direction has its own storage register and its own capture strobe. The strobes are asynchronous to the system clock. Each one passes through a synchronizer and a rising-edge detector. A detected rising edge loads the current value of the source bus into that direction's register. The enable, direction and select inputs do not affect capture.

Each direction also has a source select. A low select passes the live value of the opposite bus to the driven bus. A high select passes the stored value instead. The output multiplexer and the enables are registered, so a change of select produces a single clean step on the output.

Top module: `bidir_store_xcvr`

## Requirements
- R1: While `rst_n` is low at a clock edge, both storage registers, both output values and both output enables become zero.
- R2: One edge after `en_n` is sampled high, `a_oe` and `b_oe` are both 0.
- R3: One edge after `en_n` is sampled low, the enables follow `dir`. With `dir`=1, `b_oe`=1 and `a_oe`=0. With `dir`=0, `a_oe`=1 and `b_oe`=0. The two enables are never both 1.
- R4: With `sel_ab`=0, `b_out` equals the `a_in` value sampled at the previous edge. With `sel_ba`=0, `a_out` equals the `b_in` value sampled at the previous edge.
- R5: With `sel_ab`=1, `b_out` shows the A-to-B register. With `sel_ba`=1, `a_out` shows the B-to-A register.
- R6: A rising edge of `stb_ab` stores `a_in` in the A-to-B register, and a rising edge of `stb_ba` stores `b_in` in the B-to-A register. Counting from the first edge that sees the strobe high, the register loads at the third edge. The stored output then shows the new value after the fourth edge.
- R7: Capture takes place for any value of `en_n`, `dir`, `sel_ab` and `sel_ba`, including while the buses are isolated.
- R8: When both strobes rise in the same cycle, both registers load in the same edge.
- R9: A strobe held high, or a falling strobe, leaves the register unchanged, even when the bus value changes.
- R10: A change of select moves the output from the old source to the new source at exactly one edge. No intermediate value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_n | input | 1 | Active-low drive enable; high isolates both buses |
| dir | input | 1 | 1: drive the B bus, 0: drive the A bus |
| sel_ab | input | 1 | B-bus source: 0 = live A, 1 = A-to-B register |
| sel_ba | input | 1 | A-bus source: 0 = live B, 1 = B-to-A register |
| stb_ab | input | 1 | Asynchronous capture strobe for the A-to-B register |
| stb_ba | input | 1 | Asynchronous capture strobe for the B-to-A register |
| a_in | input | 8 | Value present on the A bus |
| a_out | output | 8 | Value the block drives onto the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_in | input | 8 | Value present on the B bus |
| b_out | output | 8 | Value the block drives onto the B bus |
| b_oe | output | 1 | Drive enable for the B bus |

## Verification
The live path is tested with several different byte patterns, changed from one cycle to the next. This shows that the output follows the opposite input with one edge of delay and does not hold a stale copy. Captures are made while the buses are isolated, with the strobe held high, on a falling strobe, with both strobes together and with `dir` pointing the other way. These patterns separate the edge detector from a level load, a shared strobe from independent ones, and a capture gated by the enables from an ungated one. The stored output is sampled after each of the four edges that follow a strobe rise, which pins down the capture latency. A select flip checked at one edge confirms the single-step output change.

// File: rtl/xcvr_pkg.sv
// Shared types for the registered transceiver.
// Assumes: at most one bus is driven at a time.
package xcvr_pkg;

    typedef enum logic [1:0] {
        DRV_NONE = 2'b00,
        DRV_A    = 2'b01,
        DRV_B    = 2'b10
    } drive_e;

    // Turn the enable and direction inputs into a drive choice.
    function automatic drive_e decode_drive(input logic en_n, input logic dir);
        if (en_n)
            return DRV_NONE;
        else if (dir)
            return DRV_B;
        else
            return DRV_A;
    endfunction

endpackage

// File: rtl/xcvr_edge_sync.sv
// Brings one asynchronous strobe into the clock domain and emits a
// one-cycle pulse for every rising edge of the strobe.
// Assumes: the strobe stays high and low for at least two clock cycles each.
module xcvr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic rise_pulse
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain;
    logic         last_level;

    // Synchronizer chain plus one flop holding the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain      <= '0;
            last_level <= 1'b0;
        end else begin
            chain      <= {chain[TOP-1:0], strobe_in};
            last_level <= chain[TOP];
        end
    end

    // A rising edge is a high synchronized level whose previous level was low.
    always_comb rise_pulse = chain[TOP] & ~last_level;

endmodule

// File: rtl/xcvr_store.sv
// Storage register for one direction. It loads on a capture pulse and
// holds its value otherwise.
// Assumes: load is a single-cycle pulse that is already in the clock domain.
module xcvr_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    // Capture the bus value on a load pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

endmodule

// File: rtl/xcvr_drive_stage.sv
// Registered source multiplexers and drive enables for both buses.
// Registering here gives one clean output step per change of select.
// Assumes: the live inputs come from the external bus values, not from
// this stage's own outputs.
module xcvr_drive_stage
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic [WIDTH-1:0] a_live,
    input  logic [WIDTH-1:0] b_live,
    input  logic [WIDTH-1:0] held_ab,
    input  logic [WIDTH-1:0] held_ba,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe_q,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe_q
);
    drive_e drive_sel;

    // Decode the drive choice from enable and direction.
    always_comb drive_sel = decode_drive(en_n, dir);

    // Each bit lane has identical logic: a registered mux and a registered enable.
    for (genvar lane = 0; lane < WIDTH; lane++) begin : g_lane
        // Register both lane multiplexers and the lane enables.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_out[lane]  <= 1'b0;
                b_out[lane]  <= 1'b0;
                a_oe_q[lane] <= 1'b0;
                b_oe_q[lane] <= 1'b0;
            end else begin
                a_out[lane]  <= sel_ba ? held_ba[lane] : b_live[lane];
                b_out[lane]  <= sel_ab ? held_ab[lane] : a_live[lane];
                a_oe_q[lane] <= (drive_sel == DRV_A);
                b_oe_q[lane] <= (drive_sel == DRV_B);
            end
        end
    end

endmodule

// File: rtl/bidir_store_xcvr.sv
// Top level of the registered bidirectional bus transceiver. It connects
// the two strobe synchronizers, the two direction registers and the drive stage.
// Assumes: the bus inputs are the external bus values. The board combines
// the out and oe pins into the physical bus.
module bidir_store_xcvr #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_n,
    input  logic             dir,
    input  logic             sel_ab,
    input  logic             sel_ba,
    input  logic             stb_ab,
    input  logic             stb_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out,
    output logic             b_oe
);
    logic             cap_ab;
    logic             cap_ba;
    logic [WIDTH-1:0] reg_ab;
    logic [WIDTH-1:0] reg_ba;
    logic [WIDTH-1:0] a_oe_lanes;
    logic [WIDTH-1:0] b_oe_lanes;

    xcvr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ab (
        .clk(clk), .rst_n(rst_n), .strobe_in(stb_ab), .rise_pulse(cap_ab)
    );

    xcvr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_ba (
        .clk(clk), .rst_n(rst_n), .strobe_in(stb_ba), .rise_pulse(cap_ba)
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store_ab (
        .clk(clk), .rst_n(rst_n), .load(cap_ab), .d(a_in), .q(reg_ab)
    );

    xcvr_store #(.WIDTH(WIDTH)) u_store_ba (
        .clk(clk), .rst_n(rst_n), .load(cap_ba), .d(b_in), .q(reg_ba)
    );

    xcvr_drive_stage #(.WIDTH(WIDTH)) u_drive (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_live(a_in), .b_live(b_in),
        .held_ab(reg_ab), .held_ba(reg_ba),
        .a_out(a_out), .a_oe_q(a_oe_lanes),
        .b_out(b_out), .b_oe_q(b_oe_lanes)
    );

    // Every lane enable carries the same value, so lane 0 drives the bus enable.
    always_comb begin
        a_oe = a_oe_lanes[0];
        b_oe = b_oe_lanes[0];
    end

endmodule

// File: rtl/xcvr_checker.sv
// Protocol checker for bidir_store_xcvr. It is attached to every
// instance of the top module with a bind statement.
// Assumes: a reset is applied before any check is meaningful.
module xcvr_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en_n,
    input logic             dir,
    input logic             sel_ab,
    input logic             sel_ba,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] b_out,
    input logic             a_oe,
    input logic             b_oe,
    input logic             cap_ab,
    input logic             cap_ba,
    input logic [WIDTH-1:0] reg_ab,
    input logic [WIDTH-1:0] reg_ba
);
    logic armed = 1'b0;

    // Arm the checks once the first reset has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b1;
    end

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed && !$past(rst_n) |-> reg_ab == '0 && reg_ba == '0 && !a_oe && !b_oe);

    p_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && $past(en_n) |-> !a_oe && !b_oe);

    p_one_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !(a_oe && b_oe));

    p_dir_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && $past(!en_n && dir) |-> b_oe);

    p_dir_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && $past(!en_n && !dir) |-> a_oe);

    p_live_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && !$past(sel_ab) |-> b_out == $past(a_in));

    p_live_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && !$past(sel_ba) |-> a_out == $past(b_in));

    p_stored_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && $past(sel_ab) |-> b_out == $past(reg_ab));

    p_stored_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && $past(sel_ba) |-> a_out == $past(reg_ba));

    p_load_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && $past(cap_ab) |-> reg_ab == $past(a_in));

    p_load_ba_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && $past(cap_ba) |-> reg_ba == $past(b_in));

    p_hold_ab_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && !$past(cap_ab) |-> $stable(reg_ab));

    p_hold_ba_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(rst_n) && !$past(cap_ba) |-> $stable(reg_ba));

endmodule

bind bidir_store_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .reg_ab(reg_ab), .reg_ba(reg_ba)
);

// File: tb/bidir_store_xcvr_tb.sv
// Scoreboard bench for bidir_store_xcvr. The driver applies stimulus just
// after a rising edge and queues the outputs it expects. The monitor pops
// and compares them at the next falling edge.
module bidir_store_xcvr_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic       stb_ab = 1'b0, stb_ba = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic [7:0] a_out, b_out;
    logic       a_oe, b_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic       aoe, boe, ca, cb;
        logic [7:0] av, bv;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    bidir_store_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .stb_ab(stb_ab), .stb_ba(stb_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    // Advance n rising edges, then settle just past the edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Queue one expected output set for the next falling edge.
    task automatic expect_out(input string tag, input logic aoe, input logic boe,
                              input logic ca, input logic [7:0] av,
                              input logic cb, input logic [7:0] bv);
        exp_t e;
        e.tag = tag; e.aoe = aoe; e.boe = boe;
        e.ca = ca; e.av = av; e.cb = cb; e.bv = bv;
        sb_q.push_back(e);
    endtask

    // Monitor: compare the design outputs with the queued expectations.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (a_oe !== e.aoe || b_oe !== e.boe ||
                (e.ca && a_out !== e.av) || (e.cb && b_out !== e.bv)) begin
                failures++;
                $display("FAIL %s: actual a_oe=%b b_oe=%b a_out=%h b_out=%h expected a_oe=%b b_oe=%b a_out=%h b_out=%h",
                         e.tag, a_oe, b_oe, a_out, b_out, e.aoe, e.boe, e.av, e.bv);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Driver: stimulus sequence.
    initial begin
        // R1: reset clears everything
        step(2);
        expect_out("R1 reset", 0, 0, 1, 8'h00, 1, 8'h00);
        step(1);
        rst_n = 1'b1;

        // R2 isolation; R4 live path still tracked while isolated
        en_n = 1'b1; a_in = 8'h3C; sel_ab = 1'b0;
        step(1);
        expect_out("R2 isolation", 0, 0, 0, 8'h00, 1, 8'h3C);

        // R3 drive B, R4 live A->B with changing patterns
        en_n = 1'b0; dir = 1'b1; a_in = 8'hA5;
        step(1);
        expect_out("R3 drive B / R4 live", 0, 1, 0, 8'h00, 1, 8'hA5);
        a_in = 8'h5A;
        step(1);
        expect_out("R4 live A->B change", 0, 1, 0, 8'h00, 1, 8'h5A);

        // R3 drive A, R4 live B->A
        dir = 1'b0; b_in = 8'hC3; sel_ba = 1'b0;
        step(1);
        expect_out("R3 drive A / R4 live B->A", 1, 0, 1, 8'hC3, 0, 8'h00);

        // R6/R7: capture while isolated with select high, latency check
        en_n = 1'b1; sel_ab = 1'b1; a_in = 8'h77; stb_ab = 1'b1;
        step(1);
        expect_out("R6 after edge 1", 0, 0, 0, 8'h00, 1, 8'h00);
        step(1);
        expect_out("R6 after edge 2", 0, 0, 0, 8'h00, 1, 8'h00);
        step(1);
        expect_out("R6 after edge 3", 0, 0, 0, 8'h00, 1, 8'h00);
        step(1);
        expect_out("R6 R7 after edge 4", 0, 0, 0, 8'h00, 1, 8'h77);

        // R9: strobe held high, then falling: no new capture
        a_in = 8'h11;
        step(4);
        expect_out("R9 held strobe", 0, 0, 0, 8'h00, 1, 8'h77);
        stb_ab = 1'b0;
        step(4);
        expect_out("R9 falling strobe", 0, 0, 0, 8'h00, 1, 8'h77);

        // R8: both strobes in one cycle; R5 stored to both buses
        a_in = 8'h99; b_in = 8'h66; sel_ba = 1'b1;
        stb_ab = 1'b1; stb_ba = 1'b1;
        step(5);
        expect_out("R8 R5 dual capture", 0, 0, 1, 8'h66, 1, 8'h99);
        stb_ab = 1'b0; stb_ba = 1'b0;
        step(3);

        // R10: select change steps the output at exactly one edge
        en_n = 1'b0; dir = 1'b1; a_in = 8'hF0; sel_ab = 1'b0;
        step(1);
        expect_out("R10 live before switch", 0, 1, 0, 8'h00, 1, 8'hF0);
        sel_ab = 1'b1;
        step(1);
        expect_out("R10 stored after one edge", 0, 1, 0, 8'h00, 1, 8'h99);

        // R7: capture into B->A while B is driven and select is high
        b_in = 8'h2B; stb_ba = 1'b1;
        step(4);
        expect_out("R7 R5 capture while driving B", 0, 1, 1, 8'h2B, 1, 8'h99);
        stb_ba = 1'b0;
        dir = 1'b0;
        step(2);
        expect_out("R5 stored to A bus", 1, 0, 1, 8'h2B, 0, 8'h00);

        // R1: mid-run reset clears the registers
        rst_n = 1'b0;
        step(1);
        expect_out("R1 mid-run reset", 0, 0, 1, 8'h00, 1, 8'h00);
        rst_n = 1'b1; en_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; sel_ba = 1'b1;
        step(2);
        expect_out("R1 registers cleared", 0, 1, 1, 8'h00, 1, 8'h00);

        step(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule